// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits on the write path of a byte-wide parallel EEPROM array controller. It watches each write strobe that reaches the device. A write is taken on the rising edge of the write strobe while chip select is high. The block looks for two fixed series of address/data writes that change software write protection. The six-write series turns protection off. The three-write series turns it on.

Each recognised series starts an internal write cycle that lasts a programmable number of clock cycles. The block reports this as busy. Turning protection on takes effect as soon as the last write of its series is taken. Turning protection off takes effect only when the write cycle ends.

Ordinary writes are passed to the array as a one-cycle permit pulse, and only while protection is off. Any write that forms part of a command series is held back from the array.

Top module: `wp_seq_guard`

## Requirements
- R1: While `rst_n` is low, `prot_on` equals parameter `PROT_RESET` (default 1), `busy` and `array_wr_ok` are 0, and the sequence tracker is idle.
- R2: A write event is a 0-to-1 change of `wr_stb`, seen on a `clk` edge while `chip_sel` is 1. A strobe edge with `chip_sel` at 0 is ignored: it gives no permit and does not move the sequence.
- R3: The unprotect series is six consecutive write events, as data@address in hex: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555.
- R4: After the sixth write event of the unprotect series, `busy` is 1 for exactly `TWC_CYCLES` clock cycles, starting on the next edge. `prot_on` stays 1 until the edge on which `busy` falls, and drops to 0 on that same edge.
- R5: The protect series is AA@5555, 55@2AAA, A0@5555. On the edge after its third write event, `prot_on` becomes 1 and `busy` becomes 1 for `TWC_CYCLES` cycles.
- R6: A write event that does not match the next expected pair aborts the series. If that write is AA@5555, it counts as the first write of a new attempt.
- R7: A write event that matches the next expected step, or that restarts a series, never raises `array_wr_ok`.
- R8: Any other write event raises `array_wr_ok` for exactly one cycle, on the edge after the event, if `prot_on` was 0. If `prot_on` was 1, `array_wr_ok` stays 0.
- R9: Write events while `busy` is 1 are ignored. They give no permit and do not advance or reset the sequence.
- R10: Only address bits 14:0 are compared with 5555 and 2AAA. Bit 15 is don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chip_sel | input | 1 | Device select from the address decode, active high |
| wr_stb | input | 1 | Write strobe shared by the array; its rising edge takes a write |
| addr | input | ADDR_W (16) | Write address |
| wdata | input | DATA_W (8) | Write data |
| prot_on | output | 1 | Software write protection active |
| busy | output | 1 | Internal write cycle in progress |
| array_wr_ok | output | 1 | One-cycle permit to pass the taken write to the array |

## Verification
The assertions check, on every cycle, the rules that hold whatever the stimulus:
- a permit never follows a cycle with protection on or with busy high;
- the permit is a single-cycle pulse;
- protection falls only on the edge where busy falls, and rises only when busy rises;
- each busy window lasts exactly the write-cycle count.

Only the bench's scenarios can show which write series is recognised. That covers the exact pair order, an abort followed by a restart on AA@5555, series sent during busy being lost, the don't-care address bit, and deselected strobes having no effect. The bench's behavioural model follows all of these cycle by cycle.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_X3,
    SQ_X4,
    SQ_X5
  } seq_st_e;

  localparam logic [14:0] KEY_LO = 15'h5555;
  localparam logic [14:0] KEY_HI = 15'h2AAA;

  localparam logic [7:0] B_AA = 8'hAA;
  localparam logic [7:0] B_55 = 8'h55;
  localparam logic [7:0] B_80 = 8'h80;
  localparam logic [7:0] B_A0 = 8'hA0;
  localparam logic [7:0] B_20 = 8'h20;

endpackage

// File: rtl/wpg_strobe_edge.sv
module wpg_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic sel,
  input  logic hold,
  output logic evt
);

  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign evt = stb & ~stb_q & sel & ~hold;

endmodule

// File: rtl/wpg_seq_fsm.sv
module wpg_seq_fsm
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_hit,
  output logic              arm_done,
  output logic              disarm_done
);

  localparam logic [ADDR_W-1:0] KMASK = ADDR_W'((64'd1 << KEY_W) - 64'd1);

  function automatic logic at_key(input logic [ADDR_W-1:0] a, input logic [14:0] k);
    return ((a ^ ADDR_W'(k)) & KMASK) == '0;
  endfunction

  seq_st_e st_q, st_d;
  logic    lo_aa, hi_55, lo_80, lo_a0, lo_20;
  logic    adv, fin_arm, fin_dis;
  seq_st_e nxt;

  assign lo_aa = at_key(addr, KEY_LO) && (wdata == DATA_W'(B_AA));
  assign hi_55 = at_key(addr, KEY_HI) && (wdata == DATA_W'(B_55));
  assign lo_80 = at_key(addr, KEY_LO) && (wdata == DATA_W'(B_80));
  assign lo_a0 = at_key(addr, KEY_LO) && (wdata == DATA_W'(B_A0));
  assign lo_20 = at_key(addr, KEY_LO) && (wdata == DATA_W'(B_20));

  always_comb begin
    adv     = 1'b0;
    nxt     = SQ_IDLE;
    fin_arm = 1'b0;
    fin_dis = 1'b0;
    case (st_q)
      SQ_IDLE: begin adv = lo_aa; nxt = SQ_K1; end
      SQ_K1:   begin adv = hi_55; nxt = SQ_K2; end
      SQ_K2: begin
        if (lo_80) begin
          adv = 1'b1; nxt = SQ_X3;
        end else if (lo_a0) begin
          adv = 1'b1; nxt = SQ_IDLE; fin_arm = 1'b1;
        end
      end
      SQ_X3:   begin adv = lo_aa; nxt = SQ_X4; end
      SQ_X4:   begin adv = hi_55; nxt = SQ_X5; end
      SQ_X5:   begin adv = lo_20; nxt = SQ_IDLE; fin_dis = lo_20; end
      default: begin adv = 1'b0; nxt = SQ_IDLE; end
    endcase
  end

  always_comb begin
    st_d        = st_q;
    cmd_hit     = 1'b0;
    arm_done    = 1'b0;
    disarm_done = 1'b0;
    if (evt) begin
      if (adv) begin
        st_d        = nxt;
        cmd_hit     = 1'b1;
        arm_done    = fin_arm;
        disarm_done = fin_dis;
      end else if (lo_aa) begin
        st_d    = SQ_K1;
        cmd_hit = 1'b1;
      end else begin
        st_d = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else if (evt) st_q <= st_d;
  end

endmodule

// File: rtl/wpg_cycle_timer.sv
module wpg_cycle_timer #(
  parameter int TWC_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);

  localparam int CNT_W = $clog2(TWC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TWC_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | busy;
    cnt_d  = cnt_q;
    if (start)     cnt_d = LOAD;
    else if (busy) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int   ADDR_W     = 16,
  parameter int   DATA_W     = 8,
  parameter int   KEY_W      = 15,
  parameter int   TWC_CYCLES = 20,
  parameter logic PROT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              prot_on,
  output logic              busy,
  output logic              array_wr_ok
);

  logic evt, cmd_hit, arm_done, disarm_done, expire, t_busy;
  logic prot_q, prot_d, pend_q, pend_d, permit_q, permit_d;

  wpg_strobe_edge u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .stb (wr_stb),
    .sel (chip_sel),
    .hold (t_busy),
    .evt (evt)
  );

  wpg_seq_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W)
  ) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .evt (evt),
    .addr (addr),
    .wdata (wdata),
    .cmd_hit (cmd_hit),
    .arm_done (arm_done),
    .disarm_done (disarm_done)
  );

  wpg_cycle_timer #(
    .TWC_CYCLES (TWC_CYCLES)
  ) u_tmr (
    .clk (clk),
    .rst_n (rst_n),
    .start (arm_done | disarm_done),
    .busy (t_busy),
    .expire (expire)
  );

  always_comb begin
    prot_d = prot_q;
    pend_d = pend_q;
    if (arm_done) begin
      prot_d = 1'b1;
    end else if (expire && pend_q) begin
      prot_d = 1'b0;
    end
    if (disarm_done)  pend_d = 1'b1;
    else if (expire)  pend_d = 1'b0;
    permit_d = evt & ~cmd_hit & ~prot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q   <= PROT_RESET;
      pend_q   <= 1'b0;
      permit_q <= 1'b0;
    end else begin
      prot_q   <= prot_d;
      pend_q   <= pend_d;
      permit_q <= permit_d;
    end
  end

  assign prot_on     = prot_q;
  assign busy        = t_busy;
  assign array_wr_ok = permit_q;

endmodule

// File: rtl/wpg_guard_chk.sv
module wpg_guard_chk #(
  parameter int TWC_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic prot_on,
  input logic busy,
  input logic array_wr_ok
);

  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  // R8
  permit_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_ok |-> !$past(prot_on));

  // R9
  permit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_ok |-> !$past(busy));

  // R8
  permit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_ok |=> !array_wr_ok);

  // R4
  unprot_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $fell(busy));

  // R5
  prot_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $rose(busy));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == TWC_CYCLES));

  // R4
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < TWC_CYCLES));

endmodule

bind wp_seq_guard wpg_guard_chk #(
  .TWC_CYCLES (TWC_CYCLES)
) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .prot_on (prot_on),
  .busy (busy),
  .array_wr_ok (array_wr_ok)
);

// File: tb/tb_wp_seq_guard.sv
`timescale 1ns/100ps
module tb_wp_seq_guard;

  localparam int TWC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        prot_on, busy, array_wr_ok;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic last_permit;

  always #2.5 clk = ~clk;

  wp_seq_guard #(.TWC_CYCLES(TWC), .PROT_RESET(1'b1)) dut (
    .clk (clk),
    .rst_n (rst_n),
    .chip_sel (chip_sel),
    .wr_stb (wr_stb),
    .addr (addr),
    .wdata (wdata),
    .prot_on (prot_on),
    .busy (busy),
    .array_wr_ok (array_wr_ok)
  );

  // Behavioural reference model
  int   m_step;
  int   m_left;
  bit   m_prot, m_pend, m_permit, m_stbq;
  int   sq_addr[6] = '{32'h5555, 32'h2AAA, 32'h5555, 32'h5555, 32'h2AAA, 32'h5555};
  int   sq_data[6] = '{32'hAA, 32'h55, 32'h80, 32'hAA, 32'h55, 32'h20};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_left = 0; m_prot = 1; m_pend = 0; m_permit = 0; m_stbq = 0;
    end else begin
      int  a;
      int  d;
      bit  ev, fin_on, fin_off;
      a = int'(addr) % 32768;
      d = int'(wdata);
      ev = wr_stb && !m_stbq && chip_sel && (m_left == 0);
      m_stbq = wr_stb;
      m_permit = 0; fin_on = 0; fin_off = 0;
      if (ev) begin
        if (m_step == 2 && a == 32'h5555 && d == 32'hA0) begin
          m_step = 0; fin_on = 1;
        end else if (a == sq_addr[m_step] && d == sq_data[m_step]) begin
          m_step++;
          if (m_step == 6) begin m_step = 0; fin_off = 1; end
        end else if (a == 32'h5555 && d == 32'hAA) begin
          m_step = 1;
        end else begin
          m_step = 0;
          m_permit = !m_prot;
        end
      end
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0 && m_pend) begin m_prot = 0; m_pend = 0; end
      end
      if (fin_on) begin m_prot = 1; m_left = TWC; end
      if (fin_off) begin m_pend = 1; m_left = TWC; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(prot_on == m_prot, "R4 prot_on vs model", prot_on, m_prot);
      chk(busy == (m_left > 0), "R9 busy vs model", busy, m_left > 0);
      chk(array_wr_ok == m_permit, "R8 permit vs model", array_wr_ok, m_permit);
    end
  end

  task automatic wr(input bit sel, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    chip_sel = sel; addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    last_permit = array_wr_ok;
    wr_stb = 1'b0; chip_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prot_on == 1'b1, "R1 prot_on", prot_on, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(array_wr_ok == 1'b0, "R1 permit", array_wr_ok, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 data write while protected
    wr(1, 16'h0100, 8'h12);
    chk(last_permit == 1'b0, "R8 protected write", last_permit, 0);

    // R6 abort mid-series, then the tail alone must do nothing
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h80);
    wr(1, 16'h0123, 8'h33);
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h20);
    chk(busy == 1'b0, "R6 abort no busy", busy, 0);
    chk(prot_on == 1'b1, "R6 abort keeps prot", prot_on, 1);

    // R6 restart on AA@5555 at step five, then R3 full series
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h80);
    wr(1, 16'h5555, 8'hAA);
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h80);
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h20);
    chk(busy == 1'b1, "R4 busy after sixth", busy, 1);
    chk(prot_on == 1'b1, "R4 prot held during busy", prot_on, 1);
    wait_idle();
    chk(prot_on == 1'b0, "R3 unprotected after cycle", prot_on, 0);

    // R8 permitted data write
    wr(1, 16'h0200, 8'h5A);
    chk(last_permit == 1'b1, "R8 permit pulse", last_permit, 1);
    // R2 deselected strobe
    wr(0, 16'h0200, 8'h5A);
    chk(last_permit == 1'b0, "R2 deselected ignored", last_permit, 0);
    // R7 command write withheld, next data write passes
    wr(1, 16'h5555, 8'hAA);
    chk(last_permit == 1'b0, "R7 command withheld", last_permit, 0);
    wr(1, 16'h0300, 8'h77);
    chk(last_permit == 1'b1, "R6 mismatch then data", last_permit, 1);

    // R5 protect series with bit 15 set (R10)
    wr(1, 16'hD555, 8'hAA); wr(1, 16'hAAAA, 8'h55);
    @(negedge clk);
    chip_sel = 1; addr = 16'hD555; wdata = 8'hA0; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; chip_sel = 0;
    chk(prot_on == 1'b1, "R5 prot set at once", prot_on, 1);
    chk(busy == 1'b1, "R10 key match high bit ignored", busy, 1);
    @(negedge clk);

    // R9 full unprotect series during busy is lost
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h80);
    wr(1, 16'h5555, 8'hAA); wr(1, 16'h2AAA, 8'h55); wr(1, 16'h5555, 8'h20);
    wait_idle();
    repeat (TWC + 2) @(negedge clk);
    chk(prot_on == 1'b1, "R9 busy writes ignored", prot_on, 1);
    chk(busy == 1'b0, "R9 no second cycle", busy, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule